// File: doc/BRIEF.md
# ADC Conversion Sequencer and Result Formatter

This block is the digital control for a delta-sigma converter. It holds an 8-bit control/status register and a 16-bit result register, decides when conversions run and when the analog side may sleep, and times each conversion by counting modulator ticks. The number of ticks depends on the selected data-rate code. A filter stage outside the block delivers signed 18-bit raw results with a one-cycle strobe. The block clips the last one accepted during a conversion to the resolution of the current data rate. It then stores the value right-justified and sign-extended.

Two operating styles are supported. In free-running mode, conversions follow each other back to back. In one-shot mode, a conversion runs only when software requests it, and the converter powers down after it. A reset request from the bus side has the same effect as the chip reset. The gain code is passed straight through to the analog front end.

Top module: `adc_conv_seq`

## Requirements
- R1: Chip reset and a bus reset request both abort any running conversion, clear the result to 0000h, and load the control register with 8Ch. 8Ch means free-running mode, rate code 11, gain code 00, with the start/busy bit reading 1.
- R2: The control register layout is: bit 7 start/busy, bits 6:5 reserved, bit 4 one-shot select, bits 3:2 rate code, bits 1:0 gain code. Bits 6:5 always read 0, whatever was written to them.
- R3: A result is clipped to the width chosen by the rate code (00: 12 bits, 01: 14 bits, 10: 15 bits, 11: 16 bits). The range is -2^(n-1) to 2^(n-1)-1. It is stored sign-extended in two's complement, so the 14-bit limits are E000h and 1FFFh.
- R4: A conversion lasts TICK_BASE times 1, 4, 8 or 16 modulator ticks for rate codes 00, 01, 10 and 11. In one-shot mode, start/busy reads 1 for exactly that many clock cycles plus one, counted from the write that starts it, when a tick arrives every cycle.
- R5: In free-running mode, each finished conversion updates the result and the next one starts at once, so the power-down output stays low. Start/busy reads 1, and values written to it are ignored.
- R6: In one-shot mode, writing 1 to start/busy powers the converter up and runs exactly one conversion. When that conversion ends, the block stores the result, clears start/busy and raises power-down.
- R7: In one-shot mode, writing 0 to start/busy has no effect. Writing 1 while a conversion is running neither restarts nor extends that conversion.
- R8: If one-shot mode is selected while a free-running conversion is in progress, that conversion finishes and its result is stored. Only then does start/busy clear and power-down rise.
- R9: Raw samples are taken only while a conversion is running; a strobe while idle is ignored. The stored result is the last sample taken, including one that arrives in the final cycle.
- R10: The result register changes only in the cycle a conversion ends or on reset, and all 16 bits change together.
- R11: The gain code output always equals bits 1:0 of the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| bus_rst_req | input | 1 | One-cycle reset request from the bus side |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read value, with status in bit 7 |
| result_q | output | 16 | Stored conversion result, two's complement |
| mod_tick | input | 1 | Modulator tick strobe |
| raw_valid | input | 1 | Raw filter result strobe |
| raw_data | input | 18 | Raw signed filter result |
| gain_sel | output | 2 | Gain code to the analog front end |
| pwr_down | output | 1 | High while no conversion runs |
| busy | output | 1 | Start/busy status as read in bit 7 |

## Verification
The hardest case to reach is a mode switch from free-running to one-shot that lands inside a conversion. The conversion phase cannot be seen from the ports, so the bench writes the mode change and sends a raw sample in the very next cycle. That sample is stored whether the running conversion ends at once or later, because a sample arriving in the final cycle is used. A second hard case is a start write that arrives mid-conversion. The bench places it a fixed number of cycles after the first start and checks that the remaining busy time equals the original schedule, not a restarted one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RAW_W = 18;
    localparam int RES_W = 16;
    localparam int CFG_W = 8;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'h8C;

    typedef enum logic [1:0] {
        RATE_R12 = 2'b00,
        RATE_R14 = 2'b01,
        RATE_R15 = 2'b10,
        RATE_R16 = 2'b11
    } rate_e;

    typedef struct packed {
        logic       one_shot;
        rate_e      rate;
        logic [1:0] gain;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '{one_shot: 1'b0, rate: RATE_R16, gain: 2'b00};

    // result width chosen by rate code
    function automatic int rate_width(rate_e r);
        case (r)
            RATE_R12: return 12;
            RATE_R14: return 14;
            RATE_R15: return 15;
            default:  return 16;
        endcase
    endfunction

    // conversion length multiplier relative to the fastest rate
    function automatic int rate_ticks(rate_e r);
        case (r)
            RATE_R12: return 1;
            RATE_R14: return 4;
            RATE_R15: return 8;
            default:  return 16;
        endcase
    endfunction

    // clamp to the selected width, right-justified and sign-extended
    function automatic logic [RES_W-1:0] clip_to_rate(logic signed [RAW_W-1:0] raw, rate_e r);
        logic signed [RAW_W-1:0] hi;
        logic signed [RAW_W-1:0] lo;
        int w;
        w  = rate_width(r);
        hi = RAW_W'((1 << (w - 1)) - 1);
        lo = ~hi;
        if (raw > hi)
            return hi[RES_W-1:0];
        else if (raw < lo)
            return lo[RES_W-1:0];
        else
            return raw[RES_W-1:0];
    endfunction

endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_all,
    input  logic       wr_en,
    input  logic [4:0] wr_fields,
    output ctl_t       ctl_o
);

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst_all)
            ctl_q <= CTL_DEFAULT;
        else if (wr_en)
            ctl_q <= ctl_t'(wr_fields);
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_seq_pkg::*;
#(
    parameter int TICK_BASE = 4
) (
    input  logic  clk,
    input  logic  rst_all,
    input  ctl_t  ctl,
    input  logic  wr_en,
    input  logic  wr_start,
    input  logic  mod_tick,
    output logic  active_o,
    output logic  start_flag_o,
    output rate_e conv_rate_o,
    output logic  conv_done_o
);

    localparam int MAX_TICKS = TICK_BASE * 16;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic             active_q;
    logic             start_flag_q;
    rate_e            rate_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             launch;
    logic             done;
    logic             arm_req;

    assign last_cnt = CNT_W'(TICK_BASE * rate_ticks(rate_q) - 1);
    assign done     = active_q && mod_tick && (cnt_q >= last_cnt);
    assign launch   = !active_q && (!ctl.one_shot || start_flag_q);
    // a start request counts only in one-shot mode while idle and not yet pending
    assign arm_req  = wr_en && wr_start && ctl.one_shot && !start_flag_q && !active_q;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            active_q     <= 1'b0;
            start_flag_q <= 1'b1;
            rate_q       <= RATE_R16;
            cnt_q        <= '0;
        end else if (launch) begin
            active_q     <= 1'b1;
            start_flag_q <= 1'b1;
            rate_q       <= ctl.rate;
            cnt_q        <= '0;
        end else if (done) begin
            cnt_q <= '0;
            if (ctl.one_shot) begin
                active_q     <= 1'b0;
                start_flag_q <= 1'b0;
            end else begin
                rate_q <= ctl.rate;
            end
        end else if (active_q && mod_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (arm_req) begin
            start_flag_q <= 1'b1;
        end
    end

    assign active_o     = active_q;
    assign start_flag_o = start_flag_q;
    assign conv_rate_o  = rate_q;
    assign conv_done_o  = done;

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
    import adc_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_all,
    input  logic                    accept,
    input  logic                    raw_valid,
    input  logic signed [RAW_W-1:0] raw_data,
    input  logic                    conv_done,
    input  rate_e                   conv_rate,
    output logic [RES_W-1:0]        result_o
);

    logic signed [RAW_W-1:0] stage_q;
    logic signed [RAW_W-1:0] pick;
    logic [RES_W-1:0]        result_q;
    logic                    take;

    assign take = accept && raw_valid;
    assign pick = take ? raw_data : stage_q;

    always_ff @(posedge clk) begin
        if (rst_all)
            stage_q <= '0;
        else if (take)
            stage_q <= raw_data;
    end

    // whole word is written in one edge
    always_ff @(posedge clk) begin
        if (rst_all)
            result_q <= '0;
        else if (conv_done)
            result_q <= clip_to_rate(pick, conv_rate);
    end

    assign result_o = result_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int TICK_BASE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rst_req,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    output logic [15:0] result_q,
    input  logic        mod_tick,
    input  logic        raw_valid,
    input  logic [17:0] raw_data,
    output logic [1:0]  gain_sel,
    output logic        pwr_down,
    output logic        busy
);

    logic  rst_all;
    ctl_t  ctl;
    logic  active;
    logic  start_flag;
    rate_e conv_rate;
    logic  conv_done;
    logic  unused_rsvd;

    assign rst_all     = rst || bus_rst_req;
    assign unused_rsvd = ^cfg_wdata[6:5];

    adc_ctl_reg u_ctl (
        .clk       (clk),
        .rst_all   (rst_all),
        .wr_en     (cfg_we),
        .wr_fields (cfg_wdata[4:0]),
        .ctl_o     (ctl)
    );

    adc_conv_ctrl #(.TICK_BASE(TICK_BASE)) u_seq (
        .clk          (clk),
        .rst_all      (rst_all),
        .ctl          (ctl),
        .wr_en        (cfg_we),
        .wr_start     (cfg_wdata[7]),
        .mod_tick     (mod_tick),
        .active_o     (active),
        .start_flag_o (start_flag),
        .conv_rate_o  (conv_rate),
        .conv_done_o  (conv_done)
    );

    adc_result_fmt u_fmt (
        .clk       (clk),
        .rst_all   (rst_all),
        .accept    (active),
        .raw_valid (raw_valid),
        .raw_data  ($signed(raw_data)),
        .conv_done (conv_done),
        .conv_rate (conv_rate),
        .result_o  (result_q)
    );

    assign busy      = !ctl.one_shot || start_flag;
    assign cfg_rdata = {busy, 2'b00, ctl.one_shot, ctl.rate, ctl.gain};
    assign gain_sel  = ctl.gain;
    assign pwr_down  = !active;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_rst_req,
    input logic        cfg_we,
    input logic [7:0]  cfg_rdata,
    input logic [15:0] result_q,
    input logic [1:0]  gain_sel,
    input logic        pwr_down,
    input logic        busy
);

    assert_bus_reset_R1: assert property (@(posedge clk) disable iff (rst)
        bus_rst_req |=> (result_q == 16'h0000 && cfg_rdata == 8'h8C && pwr_down));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6:5] == 2'b00);

    assert_freerun_busy_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[4] |-> (busy && cfg_rdata[7]));

    assert_run_reports_busy_R6: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |-> busy);

    assert_done_powers_down_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[4] && $fell(busy)) |-> pwr_down);

    assert_idle_stays_down_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[4] && !busy && !cfg_we && !bus_rst_req) |=> pwr_down);

    assert_result_only_at_end_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_q) |-> ($past(!pwr_down) || $past(bus_rst_req)));

    assert_gain_follows_R11: assert property (@(posedge clk) disable iff (rst)
        gain_sel == cfg_rdata[1:0]);

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rst_req (bus_rst_req),
    .cfg_we      (cfg_we),
    .cfg_rdata   (cfg_rdata),
    .result_q    (result_q),
    .gain_sel    (gain_sel),
    .pwr_down    (pwr_down),
    .busy        (busy)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rst_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        mod_tick = 1'b1;
    logic        raw_valid = 1'b0;
    logic [17:0] raw_data = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] result_q;
    logic [1:0]  gain_sel;
    logic        pwr_down;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc;
    int hits;

    localparam int TB_TICK = 4;

    // {rate code, raw sample, expected stored result}
    localparam logic [35:0] VEC [11] = '{
        {2'b00, 18'(5000),   16'h07FF},
        {2'b00, 18'(-5000),  16'hF800},
        {2'b00, 18'(2047),   16'h07FF},
        {2'b01, 18'(9000),   16'h1FFF},
        {2'b01, 18'(1234),   16'h04D2},
        {2'b01, 18'(-8192),  16'hE000},
        {2'b10, 18'(-20000), 16'hC000},
        {2'b11, 18'(40000),  16'h7FFF},
        {2'b11, 18'(-40000), 16'h8000},
        {2'b11, 18'(-1),     16'hFFFF},
        {2'b10, 18'(-100),   16'hFF9C}
    };

    adc_conv_seq #(.TICK_BASE(TB_TICK)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_rst_req (bus_rst_req),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .result_q    (result_q),
        .mod_tick    (mod_tick),
        .raw_valid   (raw_valid),
        .raw_data    (raw_data),
        .gain_sel    (gain_sel),
        .pwr_down    (pwr_down),
        .busy        (busy)
    );

    always #5 clk = ~clk;

    function automatic int exp_len(logic [1:0] dr);
        case (dr)
            2'b00:   return TB_TICK * 1 + 1;
            2'b01:   return TB_TICK * 4 + 1;
            2'b10:   return TB_TICK * 8 + 1;
            default: return TB_TICK * 16 + 1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // counts negedges with busy high; optionally strobes a raw sample at count `at`
    task automatic run_busy(input bit give, input logic [17:0] rv, input int at, output int n);
        n = 0;
        while (busy && n < 300) begin
            raw_valid = give && (n == at);
            raw_data  = rv;
            n++;
            @(negedge clk);
        end
        raw_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk("R1 reset cfg", cfg_rdata, 8'h8C);
        chk("R1 reset result", result_q, 16'h0000);
        chk("R1 reset pwr_down", pwr_down, 1'b1);
        chk("R11 reset gain", gain_sel, 2'b00);
        rst = 1'b0;

        // free-running conversions
        repeat (2) @(negedge clk);
        chk("R5 running after reset", pwr_down, 1'b0);
        raw_valid = 1'b1;
        raw_data  = 18'(3000);
        @(negedge clk);
        raw_valid = 1'b0;
        for (int k = 0; k < 200 && result_q !== 16'h0BB8; k++) @(negedge clk);
        chk("R5 free-run result", result_q, 16'h0BB8);
        hits = 0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (pwr_down) hits++;
        end
        chk("R5 no power-down gap", hits, 0);
        wr_cfg(8'h0C);
        chk("R5 status reads 1 after writing 0", cfg_rdata, 8'h8C);
        wr_cfg(8'h6D);
        chk("R2 reserved read zero", cfg_rdata, 8'h8D);
        chk("R11 gain output", gain_sel, 2'b01);

        // switch to one-shot during a running conversion
        wr_cfg(8'h1D);
        chk("R8 still running after switch", pwr_down, 1'b0);
        chk("R8 still busy after switch", busy, 1'b1);
        run_busy(1'b1, 18'(-700), 0, cyc);
        chk("R8 result stored", result_q, 16'hFD44);
        chk("R8 powered down", pwr_down, 1'b1);
        chk("R8 cfg after finish", cfg_rdata, 8'h1D);

        // one-shot, writing 0 does nothing
        wr_cfg(8'h1C);
        hits = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (!pwr_down || busy) hits++;
        end
        chk("R7 write 0 starts nothing", hits, 0);
        chk("R10 result held while idle", result_q, 16'hFD44);

        // table of one-shot conversions
        for (int i = 0; i < 11; i++) begin
            logic [1:0]  dr;
            logic [17:0] rv;
            logic [15:0] ev;
            dr = VEC[i][35:34];
            rv = VEC[i][33:16];
            ev = VEC[i][15:0];
            wr_cfg({1'b1, 2'b00, 1'b1, dr, 2'b10});
            run_busy(1'b1, rv, 2, cyc);
            chk($sformatf("R4 busy length vec%0d", i), cyc, exp_len(dr));
            chk($sformatf("R3 clipped result vec%0d", i), result_q, ev);
            chk($sformatf("R6 power-down after vec%0d", i), pwr_down, 1'b1);
            chk($sformatf("R6 status cleared vec%0d", i), cfg_rdata[7], 1'b0);
            chk($sformatf("R11 gain vec%0d", i), gain_sel, 2'b10);
        end

        // idle sample ignored, repeated start ignored
        @(negedge clk);
        raw_valid = 1'b1;
        raw_data  = 18'(1500);
        @(negedge clk);
        raw_valid = 1'b0;
        chk("R10 idle strobe leaves result", result_q, 16'hFF9C);
        wr_cfg(8'h94);
        repeat (4) @(negedge clk);
        wr_cfg(8'h94);
        run_busy(1'b0, '0, 0, cyc);
        chk("R7 second start does not extend", cyc, TB_TICK * 4 + 1 - 6);
        chk("R9 idle sample ignored", result_q, 16'hFF9C);

        // bus reset in the middle of a conversion
        wr_cfg(8'h9C);
        repeat (10) @(negedge clk);
        bus_rst_req = 1'b1;
        @(negedge clk);
        bus_rst_req = 1'b0;
        chk("R1 bus reset cfg", cfg_rdata, 8'h8C);
        chk("R1 bus reset result", result_q, 16'h0000);
        chk("R1 bus reset aborts", pwr_down, 1'b1);
        @(negedge clk);
        chk("R5 free-run resumes after reset", pwr_down, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule